// File: doc/BRIEF.md
# Vector Memory Effective Width Decoder

This block takes the fields of one vector load or store that decide element sizing and works out the element width and register-group multiplier that apply to that instruction alone. The inputs are a 2-bit width code, a flag that marks an indexed access, the current element width and multiplier from the vector type state, and the base register numbers of the data and index operands. The outputs are the data and index element widths, their multipliers, the register group sizes that follow from them, an illegal-instruction flag and a misaligned-register flag. The block only reads the vector type values. It never writes them back.

For strided and unit-stride accesses, the width code replaces the element width used in both the register file and memory. The multiplier then scales with it, so the ratio of element width to multiplier stays the same. For indexed accesses, the data keeps the current element width and multiplier. The width code then sizes only the index vector, and its top code means 64 bits. All widths and multipliers are carried as log2 values. The result is registered once and held until the next request.

Top module: `vmem_eew_decode`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is sampled high, and low in every other cycle. Each accepted request produces exactly one result.
- R2: While `in_valid` is low, every result output keeps its value from the previous cycle.
- R3: For a non-indexed access, the width code picks the data EEW: 00=8, 01=16, 10=32, 11=current SEW. EEW and SEW are coded as log2(bits/8): 0=8, 1=16, 2=32, 3=64.
- R4: The multiplier input is a 3-bit code: 000=1, 001=2, 010=4, 011=8, 111=1/2, 110=1/4, 101=1/8. It reads as a signed log2 value. For a non-indexed access, the data EMUL output (4-bit two's-complement log2) equals log2 EEW − log2 SEW + log2 LMUL.
- R5: `out_illegal` is set when any of these holds: the multiplier code is 100, the data EMUL lies outside −3..+3, or, for an indexed access, the index EMUL lies outside −3..+3.
- R6: For an indexed access, the data EEW equals SEW and the data EMUL equals LMUL. The index EEW is taken from the width code with 11 meaning 64 bits (code 3).
- R7: For an indexed access, the index EMUL equals log2 index EEW − log2 SEW + log2 LMUL. For a non-indexed access, both index EEW and index EMUL are 0.
- R8: `out_illegal` is also set when SEW, the data EEW or the index EEW (indexed only) is wider than the parameter ELEN.
- R9: For a legal request, each group size output is max(1, 2^EMUL). The index group size is 0 for non-indexed accesses, and both group sizes are 0 when the request is illegal.
- R10: `out_misalign` is set for a legal request when the data base register is not a multiple of the data group size, or, for an indexed access, when the index base register is not a multiple of the index group size. It is always 0 for an illegal request.
- R11: After reset, `out_valid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_width | input | 2 | Width code of the instruction |
| in_indexed | input | 1 | 1 = indexed access |
| in_sew | input | 2 | Current SEW, log2(bits/8) |
| in_lmul | input | 3 | Current LMUL code |
| in_vd | input | $clog2(NREG) | Data operand base register |
| in_vidx | input | $clog2(NREG) | Index operand base register |
| out_valid | output | 1 | Result strobe |
| out_data_eew | output | 2 | Data EEW, log2(bits/8) |
| out_idx_eew | output | 2 | Index EEW, log2(bits/8) |
| out_data_emul | output | 4 | Data EMUL, signed log2 |
| out_idx_emul | output | 4 | Index EMUL, signed log2 |
| out_data_grp | output | 4 | Data register group size |
| out_idx_grp | output | 4 | Index register group size |
| out_illegal | output | 1 | Illegal-instruction flag |
| out_misalign | output | 1 | Misaligned base register flag |

## Verification
The bench sweeps every combination of width code, indexed flag, SEW and multiplier code. A decoder that treated code 11 as SEW for indices would report the wrong index width. Dropping the SEW term would break the fixed ratio, and a missed range check would let an EMUL of 16 or 1/16 pass as legal. Fractional multipliers and the reserved code 100 are the points where a sign-extension slip shows up as a wrong group size or a missed illegal flag. A second instance with ELEN=32 shows that 64-bit widths get rejected. Idle gaps between requests expose a result register that is loaded when it should hold its value.

// File: rtl/vmem_eew_decode.sv
module vmem_eew_decode #(
  parameter int ELEN = 64,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_width,
  input  logic                    in_indexed,
  input  logic [1:0]              in_sew,
  input  logic [2:0]              in_lmul,
  input  logic [$clog2(NREG)-1:0] in_vd,
  input  logic [$clog2(NREG)-1:0] in_vidx,
  output logic                    out_valid,
  output logic [1:0]              out_data_eew,
  output logic [1:0]              out_idx_eew,
  output logic [3:0]              out_data_emul,
  output logic [3:0]              out_idx_emul,
  output logic [3:0]              out_data_grp,
  output logic [3:0]              out_idx_grp,
  output logic                    out_illegal,
  output logic                    out_misalign
);
  localparam int RW   = $clog2(NREG);
  localparam int ELOG = $clog2(ELEN) - 3;

  logic signed [4:0] sew_s, lmul_s, deew_s, ieew_s, demul_s, iemul_s;
  logic              lmul_rsv, eew_bad, ill;
  logic [3:0]        dgrp, igrp;
  logic              mis;

  function automatic logic emul_bad(input logic signed [4:0] v);
    return (v < -5'sd3) || (v > 5'sd3);
  endfunction

  function automatic logic [3:0] grp_of(input logic signed [4:0] v);
    return (v <= 5'sd0) ? 4'd1 : (4'd1 << v[1:0]);
  endfunction

  assign sew_s   = {3'b000, in_sew};
  assign lmul_s  = {{2{in_lmul[2]}}, in_lmul};
  assign deew_s  = (!in_indexed && in_width != 2'b11) ? {3'b000, in_width} : sew_s;
  assign ieew_s  = in_indexed ? {3'b000, in_width} : 5'sd0;
  assign demul_s = in_indexed ? lmul_s : deew_s - sew_s + lmul_s;
  assign iemul_s = in_indexed ? ieew_s - sew_s + lmul_s : 5'sd0;

  assign lmul_rsv = (in_lmul == 3'b100);
  assign eew_bad  = (int'(in_sew) > ELOG) ||
                    (int'(deew_s[1:0]) > ELOG) ||
                    (in_indexed && (int'(in_width) > ELOG));
  assign ill      = lmul_rsv || emul_bad(demul_s) ||
                    (in_indexed && emul_bad(iemul_s)) || eew_bad;

  assign dgrp = ill ? 4'd0 : grp_of(demul_s);
  assign igrp = (ill || !in_indexed) ? 4'd0 : grp_of(iemul_s);
  assign mis  = !ill &&
                (((in_vd & RW'(dgrp - 4'd1)) != '0) ||
                 (in_indexed && ((in_vidx & RW'(igrp - 4'd1)) != '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data_eew  <= '0;
      out_idx_eew   <= '0;
      out_data_emul <= '0;
      out_idx_emul  <= '0;
      out_data_grp  <= '0;
      out_idx_grp   <= '0;
      out_illegal   <= 1'b0;
      out_misalign  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data_eew  <= deew_s[1:0];
        out_idx_eew   <= ieew_s[1:0];
        out_data_emul <= demul_s[3:0];
        out_idx_emul  <= iemul_s[3:0];
        out_data_grp  <= dgrp;
        out_idx_grp   <= igrp;
        out_illegal   <= ill;
        out_misalign  <= mis;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({out_data_eew, out_idx_eew, out_data_emul, out_idx_emul,
                           out_data_grp, out_idx_grp, out_illegal, out_misalign})); // R2
  AST_LEGAL_EMUL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |->
      ($signed(out_data_emul) >= -4'sd3 && $signed(out_data_emul) <= 4'sd3)); // R5
  AST_GRP_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> $onehot(out_data_grp)); // R9
  AST_ILLEGAL_NO_GRP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_data_grp == 4'd0 && out_idx_grp == 4'd0)); // R9
  AST_MISALIGN_LEGAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_misalign |-> !out_illegal); // R10
endmodule

// File: tb/sim_vmem_eew_decode.sv
module sim_vmem_eew_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       in_valid = 1'b0;
  logic [1:0] in_width = '0;
  logic       in_indexed = 1'b0;
  logic [1:0] in_sew = '0;
  logic [2:0] in_lmul = '0;
  logic [4:0] in_vd = '0;
  logic [4:0] in_vidx = '0;

  logic       out_valid, b_valid;
  logic [1:0] out_data_eew, out_idx_eew, b_deew, b_ieew;
  logic [3:0] out_data_emul, out_idx_emul, out_data_grp, out_idx_grp;
  logic [3:0] b_demul, b_iemul, b_dgrp, b_igrp;
  logic       out_illegal, out_misalign, b_ill, b_mis;

  vmem_eew_decode #(.ELEN(64), .NREG(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_width(in_width),
    .in_indexed(in_indexed), .in_sew(in_sew), .in_lmul(in_lmul),
    .in_vd(in_vd), .in_vidx(in_vidx), .out_valid(out_valid),
    .out_data_eew(out_data_eew), .out_idx_eew(out_idx_eew),
    .out_data_emul(out_data_emul), .out_idx_emul(out_idx_emul),
    .out_data_grp(out_data_grp), .out_idx_grp(out_idx_grp),
    .out_illegal(out_illegal), .out_misalign(out_misalign));

  vmem_eew_decode #(.ELEN(32), .NREG(32)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_width(in_width),
    .in_indexed(in_indexed), .in_sew(in_sew), .in_lmul(in_lmul),
    .in_vd(in_vd), .in_vidx(in_vidx), .out_valid(b_valid),
    .out_data_eew(b_deew), .out_idx_eew(b_ieew),
    .out_data_emul(b_demul), .out_idx_emul(b_iemul),
    .out_data_grp(b_dgrp), .out_idx_grp(b_igrp),
    .out_illegal(b_ill), .out_misalign(b_mis));

  typedef struct packed {
    logic [1:0] deew;
    logic [1:0] ieew;
    logic [3:0] demul;
    logic [3:0] iemul;
    logic [3:0] dgrp;
    logic [3:0] igrp;
    logic       ill;
    logic       mis;
  } res_t;

  res_t  exp_q[$];
  logic  ill32_q[$];
  string tag_q[$];
  res_t  last = '0;
  int    tests = 0;
  int    fails = 0;
  bit    done = 0;

  function automatic res_t model(input int w, input int idx, input int sew,
                                 input int lm_code, input int vd, input int vx,
                                 input int elog);
    res_t r;
    int lm, de, ie, dm, im, dg, ig;
    bit ill;
    lm = (lm_code >= 4) ? lm_code - 8 : lm_code;
    if (idx == 0) begin
      de = (w == 3) ? sew : w;
      dm = de - sew + lm;
      ie = 0; im = 0;
    end else begin
      de = sew; dm = lm;
      ie = w; im = ie - sew + lm;
    end
    ill = (lm_code == 4) || dm < -3 || dm > 3 || de > elog || sew > elog ||
          (idx != 0 && (im < -3 || im > 3 || ie > elog));
    dg = ill ? 0 : (dm <= 0 ? 1 : (1 << dm));
    ig = (ill || idx == 0) ? 0 : (im <= 0 ? 1 : (1 << im));
    r.deew = 2'(de); r.ieew = 2'(ie);
    r.demul = 4'(dm); r.iemul = 4'(im);
    r.dgrp = 4'(dg); r.igrp = 4'(ig);
    r.ill = ill;
    r.mis = !ill && ((vd % (dg == 0 ? 1 : dg)) != 0 ||
                     (idx != 0 && (vx % (ig == 0 ? 1 : ig)) != 0));
    return r;
  endfunction

  task automatic send(input int w, input int idx, input int sew, input int lm,
                      input int vd, input int vx, input string tag);
    res_t r, r32;
    @(posedge clk); #2;
    in_valid = 1'b1; in_width = 2'(w); in_indexed = idx[0];
    in_sew = 2'(sew); in_lmul = 3'(lm); in_vd = 5'(vd); in_vidx = 5'(vx);
    r   = model(w, idx, sew, lm, vd, vx, 3);
    r32 = model(w, idx, sew, lm, vd, vx, 2);
    exp_q.push_back(r);
    ill32_q.push_back(r32.ill);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      in_valid = 1'b0;
      in_width = ~in_width; in_vd = ~in_vd;
    end
  endtask

  function automatic res_t actual();
    return {out_data_eew, out_idx_eew, out_data_emul, out_idx_emul,
            out_data_grp, out_idx_grp, out_illegal, out_misalign};
  endfunction

  // monitor: scoreboard pop and compare, hold and reset checks
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (out_valid) begin
          tests++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1 unexpected result: actual out_valid=1 expected 0");
          end else begin
            res_t e;
            logic e32;
            string t;
            e = exp_q.pop_front(); e32 = ill32_q.pop_front(); t = tag_q.pop_front();
            if (actual() !== e) begin
              fails++;
              $display("FAIL %s actual=%h expected=%h", t, actual(), e);
            end
            tests++;
            if (b_ill !== e32) begin
              fails++;
              $display("FAIL R8 ELEN=32 illegal: actual=%b expected=%b (%s)", b_ill, e32, t);
            end
            last = e;
          end
        end else begin
          tests++;
          if (actual() !== last) begin
            fails++;
            $display("FAIL R2/R11 hold: actual=%h expected=%h", actual(), last);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    tests++;
    if (out_valid !== 1'b0 || actual() !== '0) begin
      fails++;
      $display("FAIL R11 reset: actual=%b/%h expected=0/0", out_valid, actual());
    end
    rst_n = 1'b1;
    idle(2);
    // R3 non-indexed width codes, SEW=32 LMUL=4
    send(0, 0, 2, 2, 0, 0, "R3 e8 from e32 m4");
    send(1, 0, 2, 2, 2, 0, "R3 e16 from e32 m4");
    send(3, 0, 2, 2, 4, 0, "R3 code 11 keeps SEW");
    idle(2);
    // R4 fractional LMUL
    send(2, 0, 0, 7, 0, 0, "R4 e32 from e8 mf2 gives m2");
    send(0, 0, 3, 1, 0, 0, "R4 e8 from e64 m2 gives mf4");
    // R5 range and reserved code
    send(3, 0, 1, 4, 0, 0, "R5 reserved lmul code");
    send(2, 0, 0, 2, 0, 0, "R5 e32 from e8 m4 gives 16");
    send(0, 0, 3, 5, 0, 0, "R5 e8 from e64 mf8 gives 1/64");
    idle(1);
    // R6/R7 indexed examples
    send(0, 1, 2, 2, 8, 3, "R6 R7 e32 m4 with 8b index");
    send(3, 1, 0, 7, 1, 8, "R6 R7 e8 mf2 with 64b index");
    send(3, 1, 3, 3, 0, 0, "R7 64b index with e64 m8");
    send(3, 1, 0, 2, 0, 0, "R7 index emul 32 illegal");
    idle(3);
    // R8 only u1 flags these
    send(3, 1, 1, 0, 0, 0, "R8 64b index");
    send(3, 0, 3, 0, 0, 0, "R8 SEW 64");
    // R10 alignment
    send(0, 1, 2, 2, 6, 0, "R10 data base misaligned");
    send(3, 1, 0, 7, 1, 10, "R10 index base misaligned");
    send(1, 0, 0, 3, 3, 0, "R10 illegal never misaligned");
    idle(2);
    // exhaustive sweep R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < 256; i++) begin
      send(i & 3, (i >> 2) & 1, (i >> 3) & 3, (i >> 5) & 7,
           (i * 3) & 31, (i * 5) & 31, "R9 sweep");
      if ((i % 7) == 0) idle(1);
    end
    idle(4);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing results: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule